// File: doc/BRIEF.md
# Memory Socket Configuration Registers

This block is the byte-wide I/O register file in front of a memory controller with six module sockets. Strap inputs give what each socket holds (empty, an 8 MB module or a 32 MB module). Firmware reads two read-only bitmaps to find the fitted modules. It then programs an eight-entry end-address table, in 8 MB units, through one size-programming port. The block turns each table write into a base, size and enable for one socket window. An address decoder downstream uses those outputs.

The size port has hidden state. Each read returns the table entry at an internal index and moves the index forward by one, wrapping modulo 8. Any read of the presence port sets the index back to zero, so firmware can dump the table in order. If the auto-configure input is high during reset, the fitted sockets come out of reset enabled and packed from address 0 in socket order. The table is preloaded to match.

Access is a single-cycle request strobe with no back-pressure. Every read returns data exactly one cycle later with a valid flag. Writes take effect at the clock edge that samples them.

Top module: `sockcfg_regs`

## Requirements
- R1: A read of port 0x803 returns a byte whose bit n (n = 0..5) is 1 when socket n holds a 32 MB module and 0 otherwise; bits 7:6 read 0.
- R2: A read of port 0x804 returns a byte whose bit n is 0 when socket n holds a module and 1 when it is empty; bits 7:6 read 1.
- R3: Any read of port 0x804 sets the size-port read index to 0.
- R4: A read of port 0x820 returns the 5-bit table entry chosen by the read index, zero-extended to 8 bits, then advances the index by one modulo 8.
- R5: A write to port 0x820 stores data bits 4:0 into the table entry selected by data bits 7:5.
- R6: A write to table entry e in 1..6 whose socket s = e-1 is fitted sets that socket's base to entry s (0 when s = 0) and its size to (written value - base) modulo 32; the socket is enabled only if that size is nonzero. Writes to entries 0 and 7, or for an empty socket, leave all socket outputs unchanged. An empty socket is never enabled.
- R7: A read of port 0x841 always returns 0x01.
- R8: Writes to any port other than 0x820 have no effect. Reads of unmapped ports return 0x00.
- R9: A reset with auto-configure low clears the table, the read index and all socket base, size and enable outputs to zero.
- R10: A reset with auto-configure high enables each fitted socket with size 1 (8 MB) or 4 (32 MB), its base the sum of the sizes of the fitted sockets below it. Table entry s+1 holds the running end address after socket s, while entries 0 and 7 and all empty sockets' outputs are zero.
- R11: Every read request is answered by `io_rd_valid` high, with its data, in the following cycle; `io_rd_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_cfg | input | 1 | Pack fitted sockets at reset |
| strap_present | input | 6 | Socket n holds a module |
| strap_big | input | 6 | Module in socket n is 32 MB (else 8 MB) |
| io_req | input | 1 | Access strobe, one cycle per access |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 12 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rd_valid | output | 1 | Read data valid |
| io_rdata | output | 8 | Read data |
| sock_en | output | 6 | Socket window enable |
| sock_base | output | 30 | Per-socket base, 5 bits each, 8 MB units |
| sock_size | output | 30 | Per-socket size, 5 bits each, 8 MB units |

## Verification
Read data, its valid flag and the index side effect all come from one register stage. They are due at the first clock edge after the request. A write's table and socket-window effect is visible after that same single edge. The bench drives at the falling edge and updates its reference model at the rising edge that samples the request. It compares every output at the next falling edge, so each result is checked in exactly the cycle it is due. The idle cycle between accesses also checks that `io_rd_valid` drops again.

// File: rtl/sockcfg_pkg.sv
package sockcfg_pkg;

  localparam logic [11:0] PORT_ID   = 12'h803;
  localparam logic [11:0] PORT_PRES = 12'h804;
  localparam logic [11:0] PORT_SIZE = 12'h820;
  localparam logic [11:0] PORT_PAR  = 12'h841;

  localparam logic [7:0] PARITY_OK = 8'h01;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID,
    SEL_PRES,
    SEL_SIZE,
    SEL_PAR
  } port_sel_e;

endpackage

// File: rtl/sockcfg_decode.sv
module sockcfg_decode
  import sockcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              io_req,
  input  logic              io_we,
  input  logic [ADDR_W-1:0] io_addr,
  output port_sel_e         sel,
  output logic              rd_stb,
  output logic              size_wr,
  output logic              size_rd,
  output logic              pres_rd
);

  always_comb begin
    sel = SEL_NONE;
    if (io_addr == ADDR_W'(PORT_ID))        sel = SEL_ID;
    else if (io_addr == ADDR_W'(PORT_PRES)) sel = SEL_PRES;
    else if (io_addr == ADDR_W'(PORT_SIZE)) sel = SEL_SIZE;
    else if (io_addr == ADDR_W'(PORT_PAR))  sel = SEL_PAR;
  end

  assign rd_stb  = io_req && !io_we;
  assign size_wr = io_req && io_we && (sel == SEL_SIZE);
  assign size_rd = rd_stb && (sel == SEL_SIZE);
  assign pres_rd = rd_stb && (sel == SEL_PRES);

endmodule

// File: rtl/sockcfg_table.sv
module sockcfg_table #(
  parameter int unsigned NUM_SOCK  = 6,
  parameter int unsigned TBL_DEPTH = 8,
  parameter int unsigned END_W     = 5,
  parameter int unsigned SMALL_U   = 1,
  parameter int unsigned BIG_U     = 4,
  localparam int unsigned IDX_W    = $clog2(TBL_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      auto_cfg,
  input  logic [NUM_SOCK-1:0]       present,
  input  logic [NUM_SOCK-1:0]       big,
  input  logic                      wr_stb,
  input  logic [IDX_W-1:0]          wr_entry,
  input  logic [END_W-1:0]          wr_end,
  input  logic                      rd_adv,
  input  logic                      rd_clr,
  output logic [END_W-1:0]          rd_end,
  output logic [NUM_SOCK*END_W-1:0] start_flat,
  output logic [NUM_SOCK*END_W-1:0] auto_base_flat
);

  logic [END_W-1:0] tbl_q    [TBL_DEPTH];
  logic [END_W-1:0] auto_end [TBL_DEPTH];
  logic [END_W-1:0] cum      [NUM_SOCK+1];
  logic [IDX_W-1:0] idx_q;

  // running end address of the packed layout
  assign cum[0] = '0;
  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_cum
    logic [END_W-1:0] units;
    assign units      = !present[s] ? '0 : (big[s] ? END_W'(BIG_U) : END_W'(SMALL_U));
    assign cum[s+1]   = cum[s] + units;
    assign auto_base_flat[s*END_W +: END_W] = cum[s];
    if (s == 0) begin : g_first
      assign start_flat[s*END_W +: END_W] = '0;
    end else begin : g_rest
      assign start_flat[s*END_W +: END_W] = tbl_q[s];
    end
  end

  for (genvar e = 0; e < TBL_DEPTH; e++) begin : g_auto
    if (e >= 1 && e <= NUM_SOCK) begin : g_used
      assign auto_end[e] = cum[e];
    end else begin : g_unused
      assign auto_end[e] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < TBL_DEPTH; e++) begin
        tbl_q[e] <= auto_cfg ? auto_end[e] : '0;
      end
      idx_q <= '0;
    end else begin
      if (wr_stb && (32'(wr_entry) < TBL_DEPTH)) begin
        tbl_q[wr_entry] <= wr_end;
      end
      if (rd_clr) begin
        idx_q <= '0;
      end else if (rd_adv) begin
        idx_q <= (32'(idx_q) == TBL_DEPTH - 1) ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign rd_end = tbl_q[idx_q];

endmodule

// File: rtl/sockcfg_window.sv
module sockcfg_window #(
  parameter int unsigned NUM_SOCK  = 6,
  parameter int unsigned TBL_DEPTH = 8,
  parameter int unsigned END_W     = 5,
  parameter int unsigned SMALL_U   = 1,
  parameter int unsigned BIG_U     = 4,
  localparam int unsigned IDX_W    = $clog2(TBL_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      auto_cfg,
  input  logic [NUM_SOCK-1:0]       present,
  input  logic [NUM_SOCK-1:0]       big,
  input  logic                      wr_stb,
  input  logic [IDX_W-1:0]          wr_entry,
  input  logic [END_W-1:0]          wr_end,
  input  logic [NUM_SOCK*END_W-1:0] start_flat,
  input  logic [NUM_SOCK*END_W-1:0] auto_base_flat,
  output logic [NUM_SOCK-1:0]       en,
  output logic [NUM_SOCK*END_W-1:0] base_flat,
  output logic [NUM_SOCK*END_W-1:0] size_flat
);

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    logic             hit;
    logic             pack;
    logic [END_W-1:0] start;
    logic [END_W-1:0] diff;
    logic [END_W-1:0] units;
    logic [END_W-1:0] base_q;
    logic [END_W-1:0] size_q;
    logic             en_q;

    assign start = start_flat[s*END_W +: END_W];
    assign diff  = wr_end - start;
    assign hit   = wr_stb && (wr_entry == IDX_W'(s + 1)) && present[s];
    assign pack  = auto_cfg && present[s];
    assign units = big[s] ? END_W'(BIG_U) : END_W'(SMALL_U);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q   <= pack;
        base_q <= pack ? auto_base_flat[s*END_W +: END_W] : '0;
        size_q <= pack ? units : '0;
      end else if (hit) begin
        en_q   <= (diff != '0);
        base_q <= start;
        size_q <= diff;
      end
    end

    assign en[s]                      = en_q;
    assign base_flat[s*END_W +: END_W] = base_q;
    assign size_flat[s*END_W +: END_W] = size_q;
  end

endmodule

// File: rtl/sockcfg_regs.sv
module sockcfg_regs
  import sockcfg_pkg::*;
#(
  parameter int unsigned NUM_SOCK  = 6,
  parameter int unsigned TBL_DEPTH = 8,
  parameter int unsigned END_W     = 5,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned SMALL_U   = 1,
  parameter int unsigned BIG_U     = 4,
  localparam int unsigned IDX_W    = $clog2(TBL_DEPTH),
  localparam int unsigned WIN_W    = NUM_SOCK * END_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_cfg,
  input  logic [NUM_SOCK-1:0] strap_present,
  input  logic [NUM_SOCK-1:0] strap_big,
  input  logic              io_req,
  input  logic              io_we,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic              io_rd_valid,
  output logic [DATA_W-1:0] io_rdata,
  output logic [NUM_SOCK-1:0] sock_en,
  output logic [WIN_W-1:0]  sock_base,
  output logic [WIN_W-1:0]  sock_size
);

  port_sel_e        sel;
  logic             rd_stb, size_wr, size_rd, pres_rd;
  logic [IDX_W-1:0] wr_entry;
  logic [END_W-1:0] wr_end, rd_end;
  logic [WIN_W-1:0] start_flat, auto_base_flat;
  logic [DATA_W-1:0] rd_mux, id_byte, pres_byte;

  assign wr_entry = io_wdata[DATA_W-1 -: IDX_W];
  assign wr_end   = io_wdata[END_W-1:0];

  sockcfg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .io_req  (io_req),
    .io_we   (io_we),
    .io_addr (io_addr),
    .sel     (sel),
    .rd_stb  (rd_stb),
    .size_wr (size_wr),
    .size_rd (size_rd),
    .pres_rd (pres_rd)
  );

  sockcfg_table #(
    .NUM_SOCK(NUM_SOCK), .TBL_DEPTH(TBL_DEPTH), .END_W(END_W),
    .SMALL_U(SMALL_U), .BIG_U(BIG_U)
  ) u_table (
    .clk            (clk),
    .rst_n          (rst_n),
    .auto_cfg       (auto_cfg),
    .present        (strap_present),
    .big            (strap_big),
    .wr_stb         (size_wr),
    .wr_entry       (wr_entry),
    .wr_end         (wr_end),
    .rd_adv         (size_rd),
    .rd_clr         (pres_rd),
    .rd_end         (rd_end),
    .start_flat     (start_flat),
    .auto_base_flat (auto_base_flat)
  );

  sockcfg_window #(
    .NUM_SOCK(NUM_SOCK), .TBL_DEPTH(TBL_DEPTH), .END_W(END_W),
    .SMALL_U(SMALL_U), .BIG_U(BIG_U)
  ) u_window (
    .clk            (clk),
    .rst_n          (rst_n),
    .auto_cfg       (auto_cfg),
    .present        (strap_present),
    .big            (strap_big),
    .wr_stb         (size_wr),
    .wr_entry       (wr_entry),
    .wr_end         (wr_end),
    .start_flat     (start_flat),
    .auto_base_flat (auto_base_flat),
    .en             (sock_en),
    .base_flat      (sock_base),
    .size_flat      (sock_size)
  );

  always_comb begin
    id_byte   = DATA_W'(strap_present & strap_big);
    pres_byte = '1;
    pres_byte[NUM_SOCK-1:0] = ~strap_present;
    unique case (sel)
      SEL_ID:   rd_mux = id_byte;
      SEL_PRES: rd_mux = pres_byte;
      SEL_SIZE: rd_mux = DATA_W'(rd_end);
      SEL_PAR:  rd_mux = DATA_W'(PARITY_OK);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rd_valid <= 1'b0;
      io_rdata    <= '0;
    end else begin
      io_rd_valid <= rd_stb;
      if (rd_stb) io_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/sockcfg_regs_chk.sv
module sockcfg_regs_chk
  import sockcfg_pkg::*;
#(
  parameter int unsigned NUM_SOCK = 6,
  parameter int unsigned END_W    = 5,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SOCK-1:0]       strap_present,
  input logic [NUM_SOCK-1:0]       strap_big,
  input logic                      io_req,
  input logic                      io_we,
  input logic [ADDR_W-1:0]         io_addr,
  input logic                      io_rd_valid,
  input logic [DATA_W-1:0]         io_rdata,
  input logic [NUM_SOCK-1:0]       sock_en,
  input logic [NUM_SOCK*END_W-1:0] sock_base,
  input logic [NUM_SOCK*END_W-1:0] sock_size
);

  logic rd_req;
  assign rd_req = io_req && !io_we;

  p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> io_rd_valid);

  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !io_rd_valid);

  p_id_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && io_addr == ADDR_W'(PORT_ID)) |=>
      io_rdata == DATA_W'(strap_present & strap_big));

  p_pres_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && io_addr == ADDR_W'(PORT_PRES)) |=>
      (io_rdata[NUM_SOCK-1:0] == ~strap_present) && (&io_rdata[DATA_W-1:NUM_SOCK]));

  p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && io_addr == ADDR_W'(PORT_PAR)) |=> io_rdata == 8'h01);

  p_ro_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_we && io_addr != ADDR_W'(PORT_SIZE)) |=>
      ($stable(sock_en) && $stable(sock_base) && $stable(sock_size)));

  p_empty_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sock_en & ~strap_present) == '0);

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_chk
    p_en_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sock_en[s] |-> (sock_size[s*END_W +: END_W] != '0));
  end

endmodule

bind sockcfg_regs sockcfg_regs_chk #(
  .NUM_SOCK(NUM_SOCK), .END_W(END_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .strap_present (strap_present),
  .strap_big     (strap_big),
  .io_req        (io_req),
  .io_we         (io_we),
  .io_addr       (io_addr),
  .io_rd_valid   (io_rd_valid),
  .io_rdata      (io_rdata),
  .sock_en       (sock_en),
  .sock_base     (sock_base),
  .sock_size     (sock_size)
);

// File: tb/sockcfg_regs_tb_top.sv
`timescale 1ns/1ps
module sockcfg_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        auto_cfg = 1'b0;
  logic [5:0]  strap_present = 6'b0;
  logic [5:0]  strap_big = 6'b0;
  logic        io_req = 1'b0;
  logic        io_we = 1'b0;
  logic [11:0] io_addr = 12'h0;
  logic [7:0]  io_wdata = 8'h0;
  logic        io_rd_valid;
  logic [7:0]  io_rdata;
  logic [5:0]  sock_en;
  logic [29:0] sock_base;
  logic [29:0] sock_size;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit started = 1'b0;

  always #2.5 clk = ~clk;

  sockcfg_regs dut_i (
    .clk(clk), .rst_n(rst_n), .auto_cfg(auto_cfg),
    .strap_present(strap_present), .strap_big(strap_big),
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd_valid(io_rd_valid), .io_rdata(io_rdata),
    .sock_en(sock_en), .sock_base(sock_base), .sock_size(sock_size)
  );

  // behavioural reference model
  logic [4:0] m_tbl [8];
  int         m_idx;
  bit         m_en [6];
  logic [4:0] m_base [6];
  logic [4:0] m_size [6];
  bit         m_rv;
  logic [7:0] m_rd;
  string      m_tag;
  string      sock_tag = "R9";

  always @(posedge clk) begin
    started <= 1'b1;
    m_rv = 1'b0;
    if (!rst_n) begin
      logic [4:0] run;
      run = 5'd0;
      m_idx = 0;
      m_tbl[0] = 5'd0;
      m_tbl[7] = 5'd0;
      for (int s = 0; s < 6; s++) begin
        if (auto_cfg && strap_present[s]) begin
          m_base[s] = run;
          m_size[s] = strap_big[s] ? 5'd4 : 5'd1;
          m_en[s]   = 1'b1;
          run       = run + m_size[s];
        end else begin
          m_base[s] = 5'd0;
          m_size[s] = 5'd0;
          m_en[s]   = 1'b0;
        end
        m_tbl[s+1] = auto_cfg ? run : 5'd0;
      end
    end else if (io_req && io_we) begin
      if (io_addr == 12'h820) begin
        int e;
        e = int'(io_wdata[7:5]);
        m_tbl[e] = io_wdata[4:0];
        if (e >= 1 && e <= 6 && strap_present[e-1]) begin
          logic [4:0] st;
          st = (e == 1) ? 5'd0 : m_tbl[e-1];
          m_base[e-1] = st;
          m_size[e-1] = io_wdata[4:0] - st;
          m_en[e-1]   = (m_size[e-1] != 5'd0);
        end
      end
    end else if (io_req) begin
      m_rv = 1'b1;
      case (io_addr)
        12'h803: begin m_rd = {2'b00, strap_present & strap_big}; m_tag = "R1"; end
        12'h804: begin m_rd = {2'b11, ~strap_present}; m_idx = 0; m_tag = "R2 R3"; end
        12'h820: begin m_rd = {3'b000, m_tbl[m_idx]}; m_idx = (m_idx + 1) % 8; m_tag = "R4 R5"; end
        12'h841: begin m_rd = 8'h01; m_tag = "R7"; end
        default: begin m_rd = 8'h00; m_tag = "R8"; end
      endcase
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      check("R11", int'(io_rd_valid), int'(m_rv), "rd_valid");
      if (m_rv && io_rd_valid) check(m_tag, int'(io_rdata), int'(m_rd), "rdata");
      for (int s = 0; s < 6; s++) begin
        check(sock_tag, int'(sock_en[s]), int'(m_en[s]), $sformatf("en[%0d]", s));
        check(sock_tag, int'(sock_base[s*5 +: 5]), int'(m_base[s]), $sformatf("base[%0d]", s));
        check(sock_tag, int'(sock_size[s*5 +: 5]), int'(m_size[s]), $sformatf("size[%0d]", s));
      end
    end
  end

  task automatic access(input bit we, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    io_req = 1'b1; io_we = we; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_req = 1'b0; io_we = 1'b0;
  endtask

  task automatic do_reset(input bit ac, input logic [5:0] pres, input logic [5:0] bg);
    @(negedge clk);
    rst_n = 1'b0; auto_cfg = ac; strap_present = pres; strap_big = bg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    // phase 1: manual programming, socket 3 empty
    sock_tag = "R9";
    do_reset(1'b0, 6'b110111, 6'b100101);
    access(0, 12'h803, 0);                      // R1
    access(0, 12'h804, 0);                      // R2
    access(0, 12'h841, 0);                      // R7
    for (int i = 0; i < 9; i++) access(0, 12'h820, 0);  // R4 wrap, zero table (R9)
    sock_tag = "R6";
    access(1, 12'h820, {3'd0, 5'd3});           // entry 0: no socket
    access(1, 12'h820, {3'd1, 5'd4});           // socket 0: 0..4
    access(1, 12'h820, {3'd2, 5'd5});           // socket 1: 4..5
    access(1, 12'h820, {3'd3, 5'd9});           // socket 2: 5..9
    access(1, 12'h820, {3'd4, 5'd12});          // socket 3 empty: stays off
    access(1, 12'h820, {3'd5, 5'd12});          // socket 4: size 0 -> off
    access(1, 12'h820, {3'd6, 5'd2});           // socket 5: wraps mod 32
    access(1, 12'h820, {3'd7, 5'd31});          // entry 7: no socket
    access(1, 12'h820, {3'd2, 5'd4});           // socket 1 size 0 -> disabled
    sock_tag = "R8";
    access(1, 12'h803, 8'hFF);                  // writes to read-only ports
    access(1, 12'h804, 8'h3F);
    access(1, 12'h841, 8'h00);
    access(0, 12'h900, 0);                      // unmapped read
    access(0, 12'h821, 0);
    sock_tag = "R5";
    access(0, 12'h820, 0);                      // index continues mid-table
    access(0, 12'h820, 0);
    access(0, 12'h804, 0);                      // R3: restart at entry 0
    for (int i = 0; i < 8; i++) access(0, 12'h820, 0);
    // back-to-back reads without idle cycle (R11)
    @(negedge clk); io_req = 1'b1; io_we = 1'b0; io_addr = 12'h820;
    @(negedge clk); io_addr = 12'h841;
    @(negedge clk); io_addr = 12'h804;
    @(negedge clk); io_req = 1'b0;
    @(negedge clk);

    // phase 2: auto-configure packing
    sock_tag = "R10";
    do_reset(1'b1, 6'b101101, 6'b001100);
    access(0, 12'h804, 0);
    for (int i = 0; i < 8; i++) access(0, 12'h820, 0);
    access(0, 12'h803, 0);
    sock_tag = "R6";
    access(1, 12'h820, {3'd3, 5'd20});
    access(1, 12'h820, {3'd2, 5'd7});           // socket 1 empty: unchanged
    // phase 3: auto-configure, all fitted, all big
    sock_tag = "R10";
    do_reset(1'b1, 6'b111111, 6'b111111);
    access(0, 12'h804, 0);
    for (int i = 0; i < 8; i++) access(0, 12'h820, 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule